// File: doc/BRIEF.md
# Immediate Jump Execute Stage

This block decodes and executes one 32-bit unconditional jump instruction that carries a 16-bit immediate. It serves an in-order processor pipeline. On each cycle it takes an instruction word, the program counter of that instruction and the current machine status word. One clock later it presents the result:

- the jump target;
- a taken strobe;
- a flag saying whether a delay slot follows;
- a register-write request that holds the return address;
- the status word, changed or passed through.

Three mode bits inside the instruction choose the variant:

- **link** saves the PC in a register;
- **absolute** uses the immediate as the target instead of an offset from the PC;
- **delay** lets the next instruction complete before the target executes.

When memory-management support is enabled, a special form is recognised: a jump with all three modes set to the vector base plus 8. This form moves the user-mode and virtual-mode bits into their saved copies and clears them. Any other word is flagged as not matched and has no side effects.

Instruction bits are numbered from 0 at the most significant end, so bit k is `instr[31-k]`.

Top module: `jump_imm_unit`

## Requirements
- R1: A valid word whose bits 0–5 (`instr[31:26]`) equal 101110 and whose bits 14–15 (`instr[17:16]`) are zero raises `taken` and clears `no_match` in the next cycle.
- R2: A valid word with any other opcode, or with bits 14–15 nonzero, raises `no_match` and clears `taken`. It makes no link write, `msr_out` equals the incoming status word, and `target` and `delay_slot` read zero.
- R3: When the absolute flag (bit 12, `instr[19]`) is 0, `target` is PC plus the sign-extended immediate (bits 16–31, `instr[15:0]`), wrapping modulo 2^32.
- R4: When the absolute flag is 1, `target` is the immediate sign-extended to 32 bits.
- R5: When the link flag (bit 13, `instr[18]`) is 1 and the register field (bits 6–10, `instr[25:21]`) is nonzero, the block raises `link_we`, `link_rd` carries that field and `link_data` carries the PC.
- R6: When the register field is 0, no link write occurs, even if the link flag is 1.
- R7: `delay_slot` equals the delay flag (bit 11, `instr[20]`) of a taken jump.
- R8: When MMU support is enabled, a taken jump with delay, absolute and link all set updates the status word if its sign-extended immediate equals `VEC_BASE + 8`. Bit 12 (saved user) takes the old bit 11 (user), and bit 14 (saved virtual) takes the old bit 13 (virtual). Bits 11 and 13 are then cleared. All other bits pass through unchanged.
- R9: If any of the three flags is 0, or the immediate differs from `VEC_BASE + 8`, `msr_out` equals the incoming status word.
- R10: While `rst` is high, every output reads zero. A cycle with `in_valid` low yields no strobe: `taken`, `no_match` and `link_we` are all low.
- R11: Every output is registered, and `out_valid` follows `in_valid` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| msr_in | input | 32 | Current machine status word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| taken | output | 1 | Jump recognised and taken |
| no_match | output | 1 | Word is not this instruction |
| delay_slot | output | 1 | Next instruction executes before the target |
| target | output | 32 | Jump target address |
| link_we | output | 1 | Register-write request for the return address |
| link_rd | output | 5 | Destination register of the link write |
| link_data | output | 32 | Value to write (the PC) |
| msr_out | output | 32 | Updated status word |

## Verification
The bench applies hand-picked and pseudo-random jump words across all eight combinations of the delay, absolute and link flags. This separates relative targets from absolute ones and shows that the delay flag is independent of the others. The immediates include positive and negative values and a PC near the top of the address space. These reveal a missing sign extension or a wrong wrap-around. The register field is tried as zero and nonzero, and the opcode and reserved bits are corrupted, so that a suppressed link write can be told apart from a missing decode. The vector-plus-8 form is applied with each flag dropped in turn and with a neighbouring immediate. Each time, status words with the mode bits set and cleared show exactly when the save-and-clear takes effect.

// File: rtl/jimm_pkg.sv
package jimm_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned RSV_W  = 2;
    localparam logic [OPC_W-1:0] JIMM_OPC = 6'b101110;

    // Field layout, most significant first (bit 0 of the format is instr[31])
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] rd;
        logic              dly;
        logic              absm;
        logic              lnk;
        logic [RSV_W-1:0]  rsv;
        logic [IMM_W-1:0]  imm;
    } jimm_word_t;

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [RIDX_W-1:0] rd;
        logic              dly;
        logic              absm;
        logic              lnk;
        logic [WORD_W-1:0] simm;
    } jimm_dec_t;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              miss;
        logic              dly;
        logic [WORD_W-1:0] target;
        logic              lwe;
        logic [RIDX_W-1:0] lrd;
        logic [WORD_W-1:0] ldata;
    } jimm_res_t;

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/jimm_decode.sv
module jimm_decode
    import jimm_pkg::*;
(
    input  logic              vld,
    input  logic [WORD_W-1:0] word,
    output jimm_dec_t         dec
);
    jimm_word_t f;
    logic       form_ok;

    always_comb begin
        f       = jimm_word_t'(word);
        form_ok = (f.opc == JIMM_OPC) && (f.rsv == '0);
        dec.hit  = vld && form_ok;
        dec.miss = vld && !form_ok;
        dec.rd   = f.rd;
        dec.dly  = f.dly;
        dec.absm = f.absm;
        dec.lnk  = f.lnk;
        dec.simm = sext_imm(f.imm);
    end
endmodule

// File: rtl/jimm_target.sv
module jimm_target
    import jimm_pkg::*;
(
    input  jimm_dec_t         dec,
    input  logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] target
);
    logic [WORD_W-1:0] rel_tgt;

    always_comb begin
        rel_tgt = pc + dec.simm;
        if (!dec.hit)
            target = '0;
        else if (dec.absm)
            target = dec.simm;
        else
            target = rel_tgt;
    end
endmodule

// File: rtl/jimm_status.sv
module jimm_status
    import jimm_pkg::*;
#(
    parameter bit               MMU_EN   = 1'b1,
    parameter logic [WORD_W-1:0] VEC_BASE = '0,
    parameter int unsigned      MSR_W    = 32,
    parameter int unsigned      UM_POS   = 11,
    parameter int unsigned      UMS_POS  = 12,
    parameter int unsigned      VM_POS   = 13,
    parameter int unsigned      VMS_POS  = 14
) (
    input  jimm_dec_t        dec,
    input  logic [MSR_W-1:0] msr_in,
    output logic [MSR_W-1:0] msr_next
);
    localparam logic [WORD_W-1:0] UVEC_ADDR = VEC_BASE + WORD_W'(8);

    generate
        if (MMU_EN) begin : g_mmu
            logic uvec;
            always_comb begin
                uvec     = dec.hit && dec.dly && dec.absm && dec.lnk
                           && (dec.simm == UVEC_ADDR);
                msr_next = msr_in;
                if (uvec) begin
                    msr_next[UMS_POS] = msr_in[UM_POS];
                    msr_next[VMS_POS] = msr_in[VM_POS];
                    msr_next[UM_POS]  = 1'b0;
                    msr_next[VM_POS]  = 1'b0;
                end
            end
        end else begin : g_plain
            always_comb msr_next = msr_in;
        end
    endgenerate
endmodule

// File: rtl/jump_imm_unit.sv
module jump_imm_unit
    import jimm_pkg::*;
#(
    parameter bit               MMU_EN   = 1'b1,
    parameter logic [31:0]      VEC_BASE = 32'h0,
    parameter int unsigned      MSR_W    = 32,
    parameter int unsigned      UM_POS   = 11,
    parameter int unsigned      UMS_POS  = 12,
    parameter int unsigned      VM_POS   = 13,
    parameter int unsigned      VMS_POS  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [31:0]       pc,
    input  logic [MSR_W-1:0]  msr_in,
    output logic              out_valid,
    output logic              taken,
    output logic              no_match,
    output logic              delay_slot,
    output logic [31:0]       target,
    output logic              link_we,
    output logic [4:0]        link_rd,
    output logic [31:0]       link_data,
    output logic [MSR_W-1:0]  msr_out
);
    jimm_dec_t         dec;
    logic [WORD_W-1:0] tgt_nx;
    logic [MSR_W-1:0]  msr_nx;
    jimm_res_t         res_nx, res_q;
    logic [MSR_W-1:0]  msr_q;

    jimm_decode u_dec (
        .vld  (in_valid),
        .word (instr),
        .dec  (dec)
    );

    jimm_target u_tgt (
        .dec    (dec),
        .pc     (pc),
        .target (tgt_nx)
    );

    jimm_status #(
        .MMU_EN   (MMU_EN),
        .VEC_BASE (VEC_BASE),
        .MSR_W    (MSR_W),
        .UM_POS   (UM_POS),
        .UMS_POS  (UMS_POS),
        .VM_POS   (VM_POS),
        .VMS_POS  (VMS_POS)
    ) u_sts (
        .dec      (dec),
        .msr_in   (msr_in),
        .msr_next (msr_nx)
    );

    always_comb begin
        res_nx.valid  = in_valid;
        res_nx.taken  = dec.hit;
        res_nx.miss   = dec.miss;
        res_nx.dly    = dec.hit && dec.dly;
        res_nx.target = tgt_nx;
        res_nx.lwe    = dec.hit && dec.lnk && (dec.rd != '0);
        res_nx.lrd    = res_nx.lwe ? dec.rd : '0;
        res_nx.ldata  = res_nx.lwe ? pc : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            msr_q <= '0;
        end else begin
            res_q <= res_nx;
            msr_q <= msr_nx;
        end
    end

    assign out_valid  = res_q.valid;
    assign taken      = res_q.taken;
    assign no_match   = res_q.miss;
    assign delay_slot = res_q.dly;
    assign target     = res_q.target;
    assign link_we    = res_q.lwe;
    assign link_rd    = res_q.lrd;
    assign link_data  = res_q.ldata;
    assign msr_out    = msr_q;
endmodule

// File: rtl/jimm_checker.sv
module jimm_checker #(
    parameter int unsigned MSR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [31:0]      instr,
    input logic [31:0]      pc,
    input logic [MSR_W-1:0] msr_in,
    input logic             out_valid,
    input logic             taken,
    input logic             no_match,
    input logic             link_we,
    input logic [4:0]       link_rd,
    input logic [31:0]      link_data,
    input logic [31:0]      target,
    input logic [MSR_W-1:0] msr_out
);
    p_valid_lat_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    p_one_kind_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (taken ^ no_match));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!taken && !no_match && !link_we));

    p_rel_target_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && taken && !$past(instr[19])) |->
        target == $past(pc) + {{16{$past(instr[15])}}, $past(instr[15:0])});

    p_abs_target_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && taken && $past(instr[19])) |->
        target == {{16{$past(instr[15])}}, $past(instr[15:0])});

    p_link_pc_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && link_we) |-> (link_data == $past(pc) && taken));

    p_no_r0_r6: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_rd != 5'd0);

    p_miss_inert_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && no_match) |-> (msr_out == $past(msr_in) && !link_we));
endmodule

bind jump_imm_unit jimm_checker #(.MSR_W(MSR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .pc        (pc),
    .msr_in    (msr_in),
    .out_valid (out_valid),
    .taken     (taken),
    .no_match  (no_match),
    .link_we   (link_we),
    .link_rd   (link_rd),
    .link_data (link_data),
    .target    (target),
    .msr_out   (msr_out)
);

// File: tb/jump_imm_unit_bench.sv
module jump_imm_unit_bench;
    localparam int UM = 11, UMS = 12, VM = 13, VMS = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, pc = '0, msr_in = '0;
    logic        out_valid, taken, no_match, delay_slot, link_we;
    logic [31:0] target, link_data, msr_out;
    logic [4:0]  link_rd;

    int nchk = 0, nfail = 0;
    bit done = 0;

    typedef struct {
        bit          v, tk, nm, dl, lw;
        logic [31:0] tg, ld, ms;
        logic [4:0]  lr;
        bit          isabs, rd0, spec;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    jump_imm_unit u_jump_imm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
        .msr_in(msr_in), .out_valid(out_valid), .taken(taken), .no_match(no_match),
        .delay_slot(delay_slot), .target(target), .link_we(link_we),
        .link_rd(link_rd), .link_data(link_data), .msr_out(msr_out)
    );

    function automatic logic [31:0] enc(int op, int rd, bit d, bit a, bit l, int rsv, int imm);
        return (32'(op) << 26) | (32'(rd & 31) << 21) | (32'(d) << 20) | (32'(a) << 19)
             | (32'(l) << 18) | (32'(rsv & 3) << 16) | 32'(imm & 16'hFFFF);
    endfunction

    function automatic exp_t model(bit r, bit v, logic [31:0] w, logic [31:0] p, logic [31:0] m);
        exp_t e;
        int   opf, rdf, rsvf;
        bit   d, a, l;
        logic [31:0] s;
        e = '{default: 0};
        if (r) return e;
        e.ms = m;
        e.v  = v;
        if (!v) return e;
        opf  = int'(w / 32'h0400_0000);
        rdf  = int'((w / 32'h20_0000) % 32);
        d    = w[20]; a = w[19]; l = w[18];
        rsvf = int'((w / 32'h1_0000) % 4);
        s    = 32'(signed'(w[15:0]));
        if (opf != 46 || rsvf != 0) begin
            e.nm = 1;
            return e;
        end
        e.tk = 1;
        e.dl = d;
        e.isabs = a;
        e.tg = a ? s : p + s;
        e.rd0 = (rdf == 0);
        if (l && rdf != 0) begin
            e.lw = 1; e.lr = 5'(rdf); e.ld = p;
        end
        if (d && a && l && s == 32'd8) begin
            e.spec = 1;
            e.ms[UMS] = m[UM];
            e.ms[VMS] = m[VM];
            e.ms[UM]  = 1'b0;
            e.ms[VM]  = 1'b0;
        end
        return e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic compare(exp_t e, bit in_rst);
        if (in_rst) begin
            chk("R10 reset valid", 32'(out_valid), 0);
            chk("R10 reset taken", 32'(taken), 0);
            chk("R10 reset link", 32'(link_we), 0);
            chk("R10 reset msr", msr_out, 0);
            return;
        end
        chk("R11 valid latency", 32'(out_valid), 32'(e.v));
        chk(e.v ? "R1 taken" : "R10 idle taken", 32'(taken), 32'(e.tk));
        chk(e.v ? "R2 no_match" : "R10 idle no_match", 32'(no_match), 32'(e.nm));
        chk(e.rd0 ? "R6 link suppressed" : "R5 link_we", 32'(link_we), 32'(e.lw));
        chk(e.spec ? "R8 status update" : "R9 status pass", msr_out, e.ms);
        if (e.tk) begin
            chk(e.isabs ? "R4 absolute target" : "R3 relative target", target, e.tg);
            chk("R7 delay flag", 32'(delay_slot), 32'(e.dl));
        end
        if (e.nm) begin
            chk("R2 target zero", target, 0);
            chk("R2 delay zero", 32'(delay_slot), 0);
        end
        if (e.lw) begin
            chk("R5 link rd", 32'(link_rd), 32'(e.lr));
            chk("R5 link data", link_data, e.ld);
        end
    endtask

    // drive at negedge after comparing the result of the previous drive
    task automatic step(bit r, bit v, logic [31:0] w, logic [31:0] p, logic [31:0] m);
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) begin
            e = q.pop_front();
            compare(e, rst);
        end
        rst = r; in_valid = v; instr = w; pc = p; msr_in = m;
        q.push_back(model(r, v, w, p, m));
    endtask

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'h1ACE_B00C;
        step(1, 1, enc(46, 3, 1, 1, 1, 0, 8), 32'h100, 32'hFFFF_FFFF);
        step(1, 0, 0, 0, 0);
        // R3 relative, positive and negative offsets, wrap
        step(0, 1, enc(46, 0, 0, 0, 0, 0, 16'h0040), 32'h0000_1000, 32'h0);
        step(0, 1, enc(46, 0, 0, 0, 0, 0, 16'hFFF0), 32'h0000_1000, 32'h0);
        step(0, 1, enc(46, 0, 1, 0, 0, 0, 16'h0020), 32'hFFFF_FFF0, 32'h0);
        // R4 absolute
        step(0, 1, enc(46, 0, 0, 1, 0, 0, 16'h8000), 32'h2000_0000, 32'h0);
        step(0, 1, enc(46, 0, 1, 1, 0, 0, 16'h7FFC), 32'h2000_0000, 32'h0);
        // R5 / R6 link
        step(0, 1, enc(46, 5, 1, 0, 1, 0, 16'h0100), 32'h0000_4000, 32'h0);
        step(0, 1, enc(46, 0, 0, 0, 1, 0, 16'h0100), 32'h0000_4000, 32'h0);
        step(0, 1, enc(46, 31, 0, 1, 1, 0, 16'h0010), 32'h0000_4004, 32'h0);
        // R8 special form with status patterns
        step(0, 1, enc(46, 14, 1, 1, 1, 0, 8), 32'h0000_0500, 32'hFFFF_FFFF);
        step(0, 1, enc(46, 14, 1, 1, 1, 0, 8), 32'h0000_0500, 32'h0000_2800);
        step(0, 1, enc(46, 14, 1, 1, 1, 0, 8), 32'h0000_0500, 32'h0000_0800);
        // R9 near misses
        step(0, 1, enc(46, 14, 0, 1, 1, 0, 8), 32'h0000_0500, 32'hFFFF_FFFF);
        step(0, 1, enc(46, 14, 1, 0, 1, 0, 8), 32'h0000_0500, 32'hFFFF_FFFF);
        step(0, 1, enc(46, 14, 1, 1, 0, 0, 8), 32'h0000_0500, 32'hFFFF_FFFF);
        step(0, 1, enc(46, 14, 1, 1, 1, 0, 12), 32'h0000_0500, 32'hFFFF_FFFF);
        // R2 opcode and reserved-bit corruption
        step(0, 1, enc(47, 14, 1, 1, 1, 0, 8), 32'h0000_0500, 32'hFFFF_FFFF);
        step(0, 1, enc(46, 14, 1, 1, 1, 1, 8), 32'h0000_0500, 32'hFFFF_FFFF);
        step(0, 1, enc(46, 7, 1, 0, 1, 2, 8), 32'h0000_0500, 32'h1234_5678);
        // R10 idle cycle carrying a matching word
        step(0, 0, enc(46, 7, 1, 1, 1, 0, 8), 32'h0000_0500, 32'hFFFF_FFFF);
        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w, p, m;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = lfsr;
            if (lfsr[3:0] != 4'h0) w[31:26] = 6'b101110;
            if (lfsr[7:4] > 4'h3) w[17:16] = 2'b00;
            if (lfsr[9:8] == 2'b00) w[15:0] = 16'h0008;
            p = {lfsr[15:0] ^ lfsr[31:16], lfsr[29:16], 2'b00};
            m = ~lfsr ^ 32'h5A5A_0F0F;
            step(0, lfsr[10] | lfsr[11], w, p, m);
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule